// File: doc/BRIEF.md
# Eight-Bit ALU with Flag Generation

This block holds the arithmetic and logic datapath of an 8-bit accumulator processor. Each cycle it takes two operands, a carry input and a 4-bit operation code. It returns an 8-bit result and four status flags: negative, overflow, zero and carry. Every flag comes with its own update-enable, and so does the result. The register file can then write only what the operation defines and leave every other flag unchanged.

A single adder serves add-with-carry, subtract-with-borrow and compare. Subtraction is formed as the first operand plus the inverted second operand plus the carry, so a carry of 1 means no borrow. Compare runs the same subtraction with the carry forced to 1. It reports flags but does not write the result. Shifts and rotates work on the first operand only. Arithmetic is always binary; no decimal correction exists.

The result and the flags are registered once. An operation presented before a rising clock edge appears on the outputs just after that edge. Operand fetch and register write-back sit outside the block.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (add) gives result = (a + b + cin) mod 256 and carry = 1 when that sum exceeds 255. Result, N, V, Z and C are all enabled.
- R2: Op code 1 (subtract) gives result = (a - b - (1 - cin)) mod 256. Carry is 1 exactly when a >= b + (1 - cin) as unsigned numbers. Result, N, V, Z and C are all enabled.
- R3: Overflow is enabled only for op codes 0 and 1. It is 1 when the signed (two's complement) value of the add or subtract falls outside -128..127.
- R4: Op code 2 (compare) evaluates a - b and ignores cin. Carry is 1 when a >= b unsigned. N, Z and C are enabled; the result enable and the overflow enable stay 0.
- R5: Op codes 3, 4 and 5 give a AND b, a OR b and a XOR b respectively. Result, N and Z are enabled; C and V are not.
- R6: Op code 6 shifts a left and op code 7 shifts a right logically. A 0 enters the vacated bit, and carry takes the bit shifted out (bit 7 for the left shift, bit 0 for the right shift). Result, N, Z and C are enabled and V is not.
- R7: Op code 8 rotates a left and op code 9 rotates a right. cin enters the vacated bit, and carry takes the bit shifted out. Result, N, Z and C are enabled and V is not.
- R8: Whenever N is enabled it equals bit 7 of the computed value. Whenever Z is enabled it is 1 exactly when the computed value is zero. For compare, the computed value is the difference a - b.
- R9: Op codes 10 to 15 assert no enable at all.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge. An active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Carry input |
| res_o | output | 8 | Computed value |
| res_we_o | output | 1 | Result write enable |
| n_o | output | 1 | Negative flag |
| n_we_o | output | 1 | Negative flag update enable |
| v_o | output | 1 | Overflow flag |
| v_we_o | output | 1 | Overflow flag update enable |
| z_o | output | 1 | Zero flag |
| z_we_o | output | 1 | Zero flag update enable |
| c_o | output | 1 | Carry flag |
| c_we_o | output | 1 | Carry flag update enable |

## Verification
For add and subtract, unsigned carry-out and signed overflow both come out of the same sum in the same cycle. A slip in operand inversion or carry injection tends to break one of them and leave the other intact. The bench sweeps every first operand against sixteen spread second operands with both carry values. This hits every combination of carry and overflow, including a result of zero with the carry set. Each case is judged against integer arithmetic carried out separately in unsigned and in signed form.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_SHL = 4'd6,
        OP_SHR = 4'd7,
        OP_ROL = 4'd8,
        OP_ROR = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'd0,
        LG_OR   = 2'd1,
        LG_XOR  = 2'd2,
        LG_NONE = 2'd3
    } logic_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              res_we;
        logic              n;
        logic              n_we;
        logic              v;
        logic              v_we;
        logic              z;
        logic              z_we;
        logic              c;
        logic              c_we;
    } alu_out_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
        sum_o  = full[W-1:0];
        cout_o = full[W];
        // operands of equal sign producing a sum of the other sign
        ovf_o  = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  logic         left_i,
    input  logic         rot_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    logic fill;

    always_comb begin
        fill = rot_i & cin_i;
        if (left_i) begin
            res_o  = {a_i[W-2:0], fill};
            cout_o = a_i[W-1];
        end else begin
            res_o  = {fill, a_i[W-1:1]};
            cout_o = a_i[0];
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] res_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (sel_i)
                LG_AND:  res_o[i] = a_i[i] & b_i[i];
                LG_OR:   res_o[i] = a_i[i] | b_i[i];
                LG_XOR:  res_o[i] = a_i[i] ^ b_i[i];
                default: res_o[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              res_we_o,
    output logic              n_o,
    output logic              n_we_o,
    output logic              v_o,
    output logic              v_we_o,
    output logic              z_o,
    output logic              z_we_o,
    output logic              c_o,
    output logic              c_we_o
);
    alu_op_e           op;
    logic              sub_sel;
    logic              add_cin;
    logic              shl_sel;
    logic              rot_sel;
    logic_sel_e        lg_sel;

    logic [DATA_W-1:0] add_sum;
    logic              add_cout;
    logic              add_ovf;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic [DATA_W-1:0] lg_res;

    alu_out_t          out_d;
    alu_out_t          out_q;

    // operation decode
    always_comb begin
        op      = alu_op_e'(op_i);
        sub_sel = (op == OP_SUB) || (op == OP_CMP);
        add_cin = (op == OP_CMP) ? 1'b1 : c_i;
        shl_sel = (op == OP_SHL) || (op == OP_ROL);
        rot_sel = (op == OP_ROL) || (op == OP_ROR);
        case (op)
            OP_AND:  lg_sel = LG_AND;
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_NONE;
        endcase
    end

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (add_cin),
        .sub_i  (sub_sel),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    alu8_shift #(.W(DATA_W)) u_shift (
        .a_i    (a_i),
        .cin_i  (c_i),
        .left_i (shl_sel),
        .rot_i  (rot_sel),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (lg_sel),
        .res_o (lg_res)
    );

    // next-state assembly: result, enables, then flags from the value
    always_comb begin
        out_d = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                out_d.res    = add_sum;
                out_d.res_we = 1'b1;
                out_d.c      = add_cout;
                out_d.c_we   = 1'b1;
                out_d.v      = add_ovf;
                out_d.v_we   = 1'b1;
                out_d.n_we   = 1'b1;
                out_d.z_we   = 1'b1;
            end
            OP_CMP: begin
                out_d.res    = add_sum;
                out_d.c      = add_cout;
                out_d.c_we   = 1'b1;
                out_d.n_we   = 1'b1;
                out_d.z_we   = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                out_d.res    = lg_res;
                out_d.res_we = 1'b1;
                out_d.n_we   = 1'b1;
                out_d.z_we   = 1'b1;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                out_d.res    = sh_res;
                out_d.res_we = 1'b1;
                out_d.c      = sh_cout;
                out_d.c_we   = 1'b1;
                out_d.n_we   = 1'b1;
                out_d.z_we   = 1'b1;
            end
            default: out_d = '0;
        endcase
        out_d.n = out_d.n_we & out_d.res[DATA_W-1];
        out_d.z = out_d.z_we & ~|out_d.res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o    = out_q.res;
    assign res_we_o = out_q.res_we;
    assign n_o      = out_q.n;
    assign n_we_o   = out_q.n_we;
    assign v_o      = out_q.v;
    assign v_we_o   = out_q.v_we;
    assign z_o      = out_q.z;
    assign z_we_o   = out_q.z_we;
    assign c_o      = out_q.c;
    assign c_we_o   = out_q.c_we;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              c_i,
    input logic [DATA_W-1:0] res_o,
    input logic              res_we_o,
    input logic              n_o,
    input logic              n_we_o,
    input logic              v_o,
    input logic              v_we_o,
    input logic              z_o,
    input logic              z_we_o,
    input logic              c_o,
    input logic              c_we_o
);
    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd0) |->
        ({c_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{DATA_W{1'b0}}, $past(c_i)}))); // R1

    AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd1) |->
        (c_o == ({1'b0, $past(a_i)} >= ({1'b0, $past(b_i)} + {{DATA_W{1'b0}}, !$past(c_i)})))); // R2

    AST_OVF_ARITH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        v_we_o |-> ($past(op_i) == 4'd0 || $past(op_i) == 4'd1)); // R3

    AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd0) |->
        (v_o == (($past(a_i[DATA_W-1]) == $past(b_i[DATA_W-1])) && (res_o[DATA_W-1] != $past(a_i[DATA_W-1]))))); // R3

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd2) |-> (!res_we_o && !v_we_o && c_we_o)); // R4

    AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) >= 4'd3 && $past(op_i) <= 4'd5) |->
        (res_we_o && n_we_o && z_we_o && !c_we_o && !v_we_o)); // R5

    AST_SHL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd6) |->
        (c_o == $past(a_i[DATA_W-1]) && !res_o[0])); // R6

    AST_ROR_IN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 4'd9) |->
        (res_o[DATA_W-1] == $past(c_i) && c_o == $past(a_i[0]))); // R7

    AST_N_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        n_we_o |-> (n_o == res_o[DATA_W-1])); // R8

    AST_Z_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        z_we_o |-> (z_o == (res_o == '0))); // R8

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) > 4'd9) |->
        !(res_we_o || n_we_o || v_we_o || z_we_o || c_we_o)); // R9

endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .c_i      (c_i),
    .res_o    (res_o),
    .res_we_o (res_we_o),
    .n_o      (n_o),
    .n_we_o   (n_we_o),
    .v_o      (v_o),
    .v_we_o   (v_we_o),
    .z_o      (z_o),
    .z_we_o   (z_we_o),
    .c_o      (c_o),
    .c_we_o   (c_we_o)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] a = 8'd0;
    logic [7:0] b = 8'd0;
    logic       c = 1'b0;
    logic [7:0] res;
    logic       res_we, n, n_we, v, v_we, z, z_we, cf, c_we;

    int nvec = 0;
    int nmis = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu8_core u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b), .c_i(c),
        .res_o(res), .res_we_o(res_we), .n_o(n), .n_we_o(n_we),
        .v_o(v), .v_we_o(v_we), .z_o(z), .z_we_o(z_we),
        .c_o(cf), .c_we_o(c_we)
    );

    task automatic fld(input string tag, input string what, input int act, input int exp,
                       input int o, input int va, input int vb, input int vc, inout bit bad);
        if (act != exp) begin
            bad = 1'b1;
            $display("FAIL %s %s op=%0d a=%0d b=%0d c=%0d actual=%0d expected=%0d",
                     tag, what, o, va, vb, vc, act, exp);
        end
    endtask

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // drive at a falling edge, check at the next falling edge (one register)
    task automatic apply(input int o, input int va, input int vb, input int vc);
        int e_res, e_c, e_v, s;
        int e_rwe, e_nwe, e_vwe, e_zwe, e_cwe;
        string tag;
        bit bad;
        op = 4'(o); a = 8'(va); b = 8'(vb); c = 1'(vc);
        @(negedge clk);
        e_res = 0; e_c = 0; e_v = 0; bad = 1'b0;
        e_rwe = 1; e_nwe = 1; e_zwe = 1; e_cwe = 1; e_vwe = 0;
        case (o)
            0: begin tag = "R1"; s = va + vb + vc; e_res = s & 255; e_c = int'(s > 255);
                     s = sgn(va) + sgn(vb) + vc; e_v = int'(s > 127 || s < -128); e_vwe = 1; end
            1: begin tag = "R2"; s = va - vb - (1 - vc); e_res = s & 255; e_c = int'(s >= 0);
                     s = sgn(va) - sgn(vb) - (1 - vc); e_v = int'(s > 127 || s < -128); e_vwe = 1; end
            2: begin tag = "R4"; s = va - vb; e_res = s & 255; e_c = int'(s >= 0); e_rwe = 0; end
            3: begin tag = "R5"; e_res = va & vb; e_cwe = 0; end
            4: begin tag = "R5"; e_res = va | vb; e_cwe = 0; end
            5: begin tag = "R5"; e_res = va ^ vb; e_cwe = 0; end
            6: begin tag = "R6"; e_res = (va << 1) & 255; e_c = va >> 7; end
            7: begin tag = "R6"; e_res = va >> 1; e_c = va & 1; end
            8: begin tag = "R7"; e_res = ((va << 1) | vc) & 255; e_c = va >> 7; end
            9: begin tag = "R7"; e_res = (va >> 1) | (vc << 7); e_c = va & 1; end
            default: begin tag = "R9"; e_rwe = 0; e_nwe = 0; e_zwe = 0; e_cwe = 0; end
        endcase
        nvec++;
        fld(tag, "res_we", int'(res_we), e_rwe, o, va, vb, vc, bad);
        fld(tag, "n_we", int'(n_we), e_nwe, o, va, vb, vc, bad);
        fld(tag, "z_we", int'(z_we), e_zwe, o, va, vb, vc, bad);
        fld(tag, "c_we", int'(c_we), e_cwe, o, va, vb, vc, bad);
        fld("R3", "v_we", int'(v_we), e_vwe, o, va, vb, vc, bad);
        if (e_rwe == 1) fld(tag, "res", int'(res), e_res, o, va, vb, vc, bad);
        if (e_cwe == 1) fld(tag, "carry", int'(cf), e_c, o, va, vb, vc, bad);
        if (e_vwe == 1) fld("R3", "overflow", int'(v), e_v, o, va, vb, vc, bad);
        if (e_nwe == 1) fld("R8", "negative", int'(n), e_res >> 7, o, va, vb, vc, bad);
        if (e_zwe == 1) fld("R8", "zero", int'(z), int'(e_res == 0), o, va, vb, vc, bad);
        if (bad) nmis++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nmis++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

    initial begin
        // R10: reset clears all outputs even with a live operation on the inputs
        op = 4'd0; a = 8'd200; b = 8'd100; c = 1'b1;
        repeat (3) @(negedge clk);
        nvec++;
        if ({res, res_we, n, n_we, v, v_we, z, z_we, cf, c_we} != 17'd0) begin
            nmis++;
            $display("FAIL R10 reset outputs actual=%0h expected=0",
                     {res, res_we, n, n_we, v, v_we, z, z_we, cf, c_we});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R8: arithmetic sweep, carry and overflow together
        for (int o = 0; o < 3; o++)
            for (int va = 0; va < 256; va++)
                for (int k = 0; k < 16; k++)
                    for (int vc = 0; vc < 2; vc++)
                        apply(o, va, k * 17, vc);
        // R5: logic operations
        for (int o = 3; o < 6; o++)
            for (int va = 0; va < 256; va++)
                for (int k = 0; k < 16; k++)
                    apply(o, va, k * 17, k & 1);
        // R6 R7: shifts and rotates with both carry inputs
        for (int o = 6; o < 10; o++)
            for (int va = 0; va < 256; va++)
                for (int vc = 0; vc < 2; vc++)
                    apply(o, va, va ^ 8'h5A, vc);
        // R9: unused codes
        for (int o = 10; o < 16; o++)
            for (int va = 0; va < 256; va += 51)
                for (int vb = 0; vb < 256; vb += 85)
                    for (int vc = 0; vc < 2; vc++)
                        apply(o, va, vb, vc);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end
endmodule